// File: doc/BRIEF.md
# Single-Lane Flash Command Sequencer

This block issues one freely composed instruction to a serial flash device over a single data lane. Typical uses are reading a status register, writing a configuration register and starting an erase. The surrounding register file presents the command description as static fields. These are the opcode, the dummy clock count, the address, the mode byte, up to eight bytes to send, and a set of enables and byte counts. A one-cycle pulse on `cmd_go` then launches the command.

The sequencer captures the whole description and the clock divisor in the cycle it accepts the pulse. It lowers chip select and generates the serial clock. It then walks a fixed chain of phases and skips each one that is disabled. Bytes received in the read phase are packed little-endian into two 32-bit result words. These words are complete once the busy flag drops.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is asserted, `spi_cs_n` is 1, `spi_sclk` and `spi_mosi` are 0, `cmd_busy` is 0, `eng_idle` is 1 and both result words are zero.
- R2: With divisor code `c` on `clk_div_code` (0 to 15), every serial bit takes 2(c+1) system clocks. For the first c+1 of them `spi_sclk` is 0, and for the last c+1 it is 1. This gives an SCLK rate of the system clock divided by 2(c+1).
- R3: The phases run in a fixed order: opcode, address, mode byte, dummy clocks, write data, read data. A phase with its enable at 0 is skipped, and so is a dummy phase with a count of 0.
- R4: The opcode phase sends the 8 bits of `cmd_opcode` most significant bit first.
- R5: When `addr_en` is 1, the address phase sends N = `addr_bytes_m1`+1 bytes (1 to 4). These are bits 8N-1 down to 0 of `cmd_addr`, sent most significant bit first.
- R6: When `mode_en` is 1, the 8 bits of `mode_byte` are sent most significant bit first, directly after the address phase.
- R7: The dummy phase lasts `cmd_dummy` serial clocks (0 to 31). During it `spi_mosi` is 0. `spi_mosi` is also 0 throughout the read phase and while chip select is high.
- R8: When `wr_en` is 1, the write phase sends N = `wr_bytes_m1`+1 bytes (1 to 8). Byte k is bits 8k+7..8k of the 64-bit value {`wr_hi`,`wr_lo`}. Byte 0 goes first, and each byte is sent most significant bit first.
- R9: When `rd_en` is 1, the read phase receives N = `rd_bytes_m1`+1 bytes (1 to 8). `spi_miso` is sampled at the system clock edge on which `spi_sclk` rises. The j-th bit received of byte k lands in bit 8k+7-j of {`rd_hi`,`rd_lo`}. Both words clear when a command is accepted, so unreceived bytes read as zero.
- R10: A `cmd_go` pulse seen while idle is accepted. At the next edge, `spi_cs_n` falls and `cmd_busy` rises. All command fields and the divisor code are captured at that edge, and later changes to them do not affect the running command.
- R11: `cmd_busy` is 1 exactly while `spi_cs_n` is 0, and `eng_idle` is always its complement. After the last bit's high half, chip select rises and busy falls on the same edge, with `spi_sclk` back at 0.
- R12: A `cmd_go` pulse while `cmd_busy` is 1 is ignored. The running command keeps its length and its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_opcode | input | 8 | Instruction opcode |
| cmd_dummy | input | 5 | Dummy clock count, 0 to 31 |
| addr_en | input | 1 | Enable address phase |
| addr_bytes_m1 | input | 2 | Address byte count minus one |
| mode_en | input | 1 | Enable mode byte phase |
| mode_byte | input | 8 | Mode byte value |
| wr_en | input | 1 | Enable write data phase |
| wr_bytes_m1 | input | 3 | Write byte count minus one |
| rd_en | input | 1 | Enable read data phase |
| rd_bytes_m1 | input | 3 | Read byte count minus one |
| cmd_addr | input | 32 | Command address |
| wr_lo | input | 32 | Write bytes 0 to 3 |
| wr_hi | input | 32 | Write bytes 4 to 7 |
| clk_div_code | input | 4 | Divisor code, divisor = 2(code+1) |
| cmd_go | input | 1 | Start pulse |
| cmd_busy | output | 1 | Command in progress |
| eng_idle | output | 1 | No command in progress |
| rd_lo | output | 32 | Received bytes 0 to 3 |
| rd_hi | output | 32 | Received bytes 4 to 7 |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bound checker watches the properties that hold at every edge:
- busy and idle stay complementary;
- SCLK and MOSI sit low while chip select is high;
- MOSI never changes during a high SCLK half;
- an accepted start pulse drops chip select at the next edge;
- the result words hold still while the engine is idle.

Only the bench's scenarios can show that the bit stream has the right content. That covers the phase ordering and skipping, the byte counts stored minus one, the little-endian packing of written and read bytes, the divisor timing, and the cases where a mid-command start pulse or a changed field is ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BYTE_W     = 8;
    localparam int OPC_W      = 8;
    localparam int MODE_W     = 8;
    localparam int DUMMY_W    = 5;
    localparam int DIV_W      = 4;
    localparam int ADDR_BYTES = 4;
    localparam int DATA_BYTES = 8;

    localparam int ADDR_W   = ADDR_BYTES * BYTE_W;
    localparam int DATA_W   = DATA_BYTES * BYTE_W;
    localparam int WORD_W   = DATA_W / 2;
    localparam int ABYTE_CW = $clog2(ADDR_BYTES);
    localparam int DBYTE_CW = $clog2(DATA_BYTES);
    localparam int BITCNT_W = $clog2(DATA_W + 1);
    localparam int BYTE_SH  = $clog2(BYTE_W);
    localparam int AIDX_W   = $clog2(ADDR_W);
    localparam int DIDX_W   = $clog2(DATA_W);

    // R3: enum order is the transmit order of the phases
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_OPC   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_MODE  = 3'd3,
        PH_DUMMY = 3'd4,
        PH_WDATA = 3'd5,
        PH_RDATA = 3'd6
    } phase_e;

    typedef struct packed {
        logic [OPC_W-1:0]    opcode;
        logic [DUMMY_W-1:0]  dummy;
        logic                addr_en;
        logic [ABYTE_CW-1:0] addr_m1;
        logic                mode_en;
        logic [MODE_W-1:0]   mode;
        logic                wr_en;
        logic [DBYTE_CW-1:0] wr_m1;
        logic                rd_en;
        logic [DBYTE_CW-1:0] rd_m1;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DIV_W-1:0]    div_m1;
    } cmd_cfg_t;

    function automatic logic phase_on(input phase_e ph, input cmd_cfg_t c);
        case (ph)
            PH_OPC:   return 1'b1;
            PH_ADDR:  return c.addr_en;
            PH_MODE:  return c.mode_en;
            PH_DUMMY: return (c.dummy != '0);
            PH_WDATA: return c.wr_en;
            PH_RDATA: return c.rd_en;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [BITCNT_W-1:0] phase_bits(input phase_e ph, input cmd_cfg_t c);
        case (ph)
            PH_OPC:   return BITCNT_W'(OPC_W);
            PH_ADDR:  return BITCNT_W'((int'(c.addr_m1) + 1) * BYTE_W);
            PH_MODE:  return BITCNT_W'(MODE_W);
            PH_DUMMY: return BITCNT_W'(c.dummy);
            PH_WDATA: return BITCNT_W'((int'(c.wr_m1) + 1) * BYTE_W);
            PH_RDATA: return BITCNT_W'((int'(c.rd_m1) + 1) * BYTE_W);
            default:  return '0;
        endcase
    endfunction

    // lowest enabled phase above the current one, else idle
    function automatic phase_e next_phase(input phase_e ph, input cmd_cfg_t c);
        phase_e res;
        res = PH_IDLE;
        for (int i = int'(PH_RDATA); i >= int'(PH_OPC); i--) begin
            if (i > int'(ph) && phase_on(phase_e'(i), c)) begin
                res = phase_e'(i);
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/flash_sclk_gen.sv
module flash_sclk_gen
    import flash_cmd_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] half_m1,
    output logic          rise_tick,
    output logic          bit_end,
    output logic          sclk
);
    localparam int CNT_W = DW + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rise_tick = run && (st_q.cnt == {1'b0, half_m1});
        bit_end   = run && (st_q.cnt == {half_m1, 1'b1});
        if (!run || bit_end) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (rise_tick) begin
                st_d.sclk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.sclk;

endmodule

// File: rtl/flash_phase_ctrl.sv
module flash_phase_ctrl
    import flash_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                bit_end,
    input  cmd_cfg_t            cfg_in,
    output phase_e              phase,
    output logic [BITCNT_W-1:0] bit_idx,
    output cmd_cfg_t            cfg,
    output logic                start
);
    typedef struct packed {
        phase_e              ph;
        logic [BITCNT_W-1:0] bits;
        cmd_cfg_t            cfg;
    } seq_st_t;

    seq_st_t             st_d, st_q;
    logic                last_bit;
    logic [BITCNT_W-1:0] ph_len;

    always_comb begin
        st_d     = st_q;
        start    = go && (st_q.ph == PH_IDLE);
        ph_len   = phase_bits(st_q.ph, st_q.cfg);
        last_bit = (st_q.bits == ph_len - BITCNT_W'(1));
        if (start) begin
            st_d.ph   = PH_OPC;
            st_d.bits = '0;
            st_d.cfg  = cfg_in;
        end else if (st_q.ph != PH_IDLE && bit_end) begin
            if (last_bit) begin
                st_d.ph   = next_phase(st_q.ph, st_q.cfg);
                st_d.bits = '0;
            end else begin
                st_d.bits = st_q.bits + BITCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.ph;
    assign bit_idx = st_q.bits;
    assign cfg     = st_q.cfg;

endmodule

// File: rtl/flash_shift_dp.sv
module flash_shift_dp
    import flash_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  phase_e              phase,
    input  logic [BITCNT_W-1:0] bit_idx,
    input  cmd_cfg_t            cfg,
    input  logic                rise_tick,
    input  logic                miso,
    output logic                mosi,
    output logic [DATA_W-1:0]   rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } rx_st_t;

    rx_st_t              st_d, st_q;
    logic [BYTE_SH-1:0]  bit_pos;
    logic [BITCNT_W-1:0] addr_last;
    logic [BITCNT_W-1:0] addr_pos;
    logic [DIDX_W-1:0]   data_pos;

    // byte-serial MSB-first position decode, no shift register
    always_comb begin
        bit_pos   = ~bit_idx[BYTE_SH-1:0];
        addr_last = BITCNT_W'((int'(cfg.addr_m1) + 1) * BYTE_W - 1);
        addr_pos  = addr_last - bit_idx;
        data_pos  = {bit_idx[DIDX_W-1:BYTE_SH], bit_pos};
    end

    always_comb begin
        case (phase)
            PH_OPC:   mosi = cfg.opcode[bit_pos];
            PH_ADDR:  mosi = cfg.addr[addr_pos[AIDX_W-1:0]];
            PH_MODE:  mosi = cfg.mode[bit_pos];
            PH_WDATA: mosi = cfg.wdata[data_pos];
            default:  mosi = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.rd = '0;
        end else if (rise_tick && phase == PH_RDATA) begin
            st_d.rd[data_pos] = miso;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPC_W-1:0]    cmd_opcode,
    input  logic [DUMMY_W-1:0]  cmd_dummy,
    input  logic                addr_en,
    input  logic [ABYTE_CW-1:0] addr_bytes_m1,
    input  logic                mode_en,
    input  logic [MODE_W-1:0]   mode_byte,
    input  logic                wr_en,
    input  logic [DBYTE_CW-1:0] wr_bytes_m1,
    input  logic                rd_en,
    input  logic [DBYTE_CW-1:0] rd_bytes_m1,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [WORD_W-1:0]   wr_lo,
    input  logic [WORD_W-1:0]   wr_hi,
    input  logic [DIV_W-1:0]    clk_div_code,
    input  logic                cmd_go,
    output logic                cmd_busy,
    output logic                eng_idle,
    output logic [WORD_W-1:0]   rd_lo,
    output logic [WORD_W-1:0]   rd_hi,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    cmd_cfg_t            cfg_in;
    cmd_cfg_t            cfg_run;
    phase_e              phase;
    logic [BITCNT_W-1:0] bit_idx;
    logic                start;
    logic                active;
    logic                rise_tick;
    logic                bit_end;
    logic                mosi_raw;
    logic [DATA_W-1:0]   rd_data;

    always_comb begin
        cfg_in.opcode  = cmd_opcode;
        cfg_in.dummy   = cmd_dummy;
        cfg_in.addr_en = addr_en;
        cfg_in.addr_m1 = addr_bytes_m1;
        cfg_in.mode_en = mode_en;
        cfg_in.mode    = mode_byte;
        cfg_in.wr_en   = wr_en;
        cfg_in.wr_m1   = wr_bytes_m1;
        cfg_in.rd_en   = rd_en;
        cfg_in.rd_m1   = rd_bytes_m1;
        cfg_in.addr    = cmd_addr;
        cfg_in.wdata   = {wr_hi, wr_lo};
        cfg_in.div_m1  = clk_div_code;
    end

    flash_phase_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (cmd_go),
        .bit_end (bit_end),
        .cfg_in  (cfg_in),
        .phase   (phase),
        .bit_idx (bit_idx),
        .cfg     (cfg_run),
        .start   (start)
    );

    assign active = (phase != PH_IDLE);

    flash_sclk_gen #(.DW(DIV_W)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .half_m1   (cfg_run.div_m1),
        .rise_tick (rise_tick),
        .bit_end   (bit_end),
        .sclk      (spi_sclk)
    );

    flash_shift_dp u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .cfg       (cfg_run),
        .rise_tick (rise_tick),
        .miso      (spi_miso),
        .mosi      (mosi_raw),
        .rd_data   (rd_data)
    );

    assign spi_mosi = active & mosi_raw;
    assign spi_cs_n = ~active;
    assign cmd_busy = active;
    assign eng_idle = ~active;
    assign rd_lo    = rd_data[WORD_W-1:0];
    assign rd_hi    = rd_data[DATA_W-1:WORD_W];

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_go,
    input logic        cmd_busy,
    input logic        eng_idle,
    input logic        spi_cs_n,
    input logic        spi_sclk,
    input logic        spi_mosi,
    input logic [31:0] rd_lo,
    input logic [31:0] rd_hi
);
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) cmd_busy != eng_idle); // R11
    AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> (!spi_sclk && !spi_mosi)); // R7
    AST_GO_SELECTS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_go && eng_idle) |=> !spi_cs_n); // R10
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R2
    AST_CS_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_cs_n) |-> !spi_sclk); // R11
    AST_RD_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (eng_idle && !cmd_go) |=> ($stable(rd_lo) && $stable(rd_hi))); // R9
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_go   (cmd_go),
    .cmd_busy (cmd_busy),
    .eng_idle (eng_idle),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
    localparam real TCK = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd_opcode = '0;
    logic [4:0]  cmd_dummy = '0;
    logic        addr_en = 1'b0;
    logic [1:0]  addr_bytes_m1 = '0;
    logic        mode_en = 1'b0;
    logic [7:0]  mode_byte = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_bytes_m1 = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_bytes_m1 = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] wr_lo = '0;
    logic [31:0] wr_hi = '0;
    logic [3:0]  clk_div_code = '0;
    logic        cmd_go = 1'b0;
    logic        spi_miso = 1'b0;
    logic        cmd_busy, eng_idle, spi_sclk, spi_cs_n, spi_mosi;
    logic [31:0] rd_lo, rd_hi;

    int n_checks = 0;
    int n_fails  = 0;
    bit cmp_on   = 1'b0;
    bit done     = 1'b0;

    always #(TCK/2) clk = ~clk;

    flash_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_opcode(cmd_opcode), .cmd_dummy(cmd_dummy),
        .addr_en(addr_en), .addr_bytes_m1(addr_bytes_m1), .mode_en(mode_en),
        .mode_byte(mode_byte), .wr_en(wr_en), .wr_bytes_m1(wr_bytes_m1),
        .rd_en(rd_en), .rd_bytes_m1(rd_bytes_m1), .cmd_addr(cmd_addr),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .clk_div_code(clk_div_code),
        .cmd_go(cmd_go), .cmd_busy(cmd_busy), .eng_idle(eng_idle),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic void chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endfunction

    // ---------------- behavioural reference model ----------------
    int        m_tx[$];
    int        m_rx[$];
    string     m_tag[$];
    bit        m_act = 1'b0;
    int        m_b = 0;
    int        m_c = 0;
    int        m_h = 1;
    int        m_len = 0;
    logic [63:0] m_rd = '0;

    function automatic void push_byte(input logic [7:0] v, input string tag);
        for (int j = 7; j >= 0; j--) begin
            m_tx.push_back(int'(v[j]));
            m_rx.push_back(-1);
            m_tag.push_back(tag);
        end
    endfunction

    function automatic void build_cmd();
        logic [63:0] wd;
        m_tx.delete(); m_rx.delete(); m_tag.delete();
        push_byte(cmd_opcode, "R4");
        if (addr_en) begin
            for (int k = int'(addr_bytes_m1); k >= 0; k--) push_byte(cmd_addr[8*k +: 8], "R5");
        end
        if (mode_en) push_byte(mode_byte, "R6");
        for (int k = 0; k < int'(cmd_dummy); k++) begin
            m_tx.push_back(0); m_rx.push_back(-1); m_tag.push_back("R7");
        end
        wd = {wr_hi, wr_lo};
        if (wr_en) begin
            for (int k = 0; k <= int'(wr_bytes_m1); k++) push_byte(wd[8*k +: 8], "R8");
        end
        if (rd_en) begin
            for (int k = 0; k <= int'(rd_bytes_m1); k++) begin
                for (int j = 0; j < 8; j++) begin
                    m_tx.push_back(0); m_rx.push_back(8*k + 7 - j); m_tag.push_back("R7");
                end
            end
        end
        m_h   = int'(clk_div_code) + 1;
        m_len = m_tx.size() * 2 * m_h;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 1'b0; m_b = 0; m_c = 0; m_rd = '0;
        end else if (m_act) begin
            if (m_c == m_h - 1 && m_rx[m_b] >= 0) m_rd[m_rx[m_b]] = spi_miso;
            if (m_c == 2*m_h - 1) begin
                m_c = 0;
                m_b++;
                if (m_b == m_tx.size()) m_act = 1'b0;
            end else begin
                m_c++;
            end
        end else if (cmd_go) begin
            build_cmd();
            m_rd = '0; m_act = 1'b1; m_b = 0; m_c = 0;
        end
    end

    // device side data source, changes away from the sampling edge
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        spi_miso <= lfsr[0];
    end

    // compare every cycle
    int busy_cnt = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R11 cs_n", 64'(spi_cs_n), 64'(!m_act));
            chk("R11 busy", 64'(cmd_busy), 64'(m_act));
            chk("R11 idle", 64'(eng_idle), 64'(!m_act));
            chk("R2 sclk", 64'(spi_sclk), 64'(m_act && (m_c >= m_h)));
            if (m_act) chk({m_tag[m_b], " R3 mosi"}, 64'(spi_mosi), 64'(m_tx[m_b]));
            else       chk("R7 mosi idle", 64'(spi_mosi), 64'd0);
            chk("R9 rd", {rd_hi, rd_lo}, m_rd);
            if (cmd_busy) busy_cnt++;
        end
    end

    task automatic pulse_go();
        @(negedge clk); cmd_go = 1'b1;
        @(negedge clk); cmd_go = 1'b0;
    endtask

    task automatic wait_done();
        while (m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cmd(input logic [7:0] op, input logic [4:0] dm, input logic ae,
                           input logic [1:0] am, input logic me, input logic we,
                           input logic [2:0] wm, input logic re, input logic [2:0] rm,
                           input logic [3:0] dv);
        cmd_opcode = op; cmd_dummy = dm; addr_en = ae; addr_bytes_m1 = am;
        mode_en = me; wr_en = we; wr_bytes_m1 = wm; rd_en = re; rd_bytes_m1 = rm;
        clk_div_code = dv;
    endtask

    task automatic run_and_count(input string tag);
        busy_cnt = 0;
        pulse_go();
        wait_done();
        chk(tag, 64'(busy_cnt), 64'(m_len));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 cs_n", 64'(spi_cs_n), 64'd1);
        chk("R1 sclk", 64'(spi_sclk), 64'd0);
        chk("R1 mosi", 64'(spi_mosi), 64'd0);
        chk("R1 busy", 64'(cmd_busy), 64'd0);
        chk("R1 idle", 64'(eng_idle), 64'd1);
        chk("R1 rd", {rd_hi, rd_lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // opcode only, fastest clock (R4, R2)
        set_cmd(8'hA5, 5'd0, 0, 2'd0, 0, 0, 3'd0, 0, 3'd0, 4'd0);
        run_and_count("R2 len opc");

        // status read: opcode + one read byte (R9)
        set_cmd(8'h05, 5'd0, 0, 2'd0, 0, 0, 3'd0, 1, 3'd0, 4'd1);
        run_and_count("R9 len status");

        // address 3 bytes, mode, 8 dummies, 8 read bytes (R5 R6 R7 R9)
        cmd_addr = 32'h12_34_56_78; mode_byte = 8'h3C;
        set_cmd(8'h6B, 5'd8, 1, 2'd2, 1, 0, 3'd0, 1, 3'd7, 4'd3);
        run_and_count("R3 len read");

        // program: 4 address bytes, 5 write bytes (R8)
        cmd_addr = 32'hDEAD_BEEF; wr_lo = 32'h4433_2211; wr_hi = 32'h8877_6655;
        set_cmd(8'h02, 5'd0, 1, 2'd3, 0, 1, 3'd4, 0, 3'd0, 4'd0);
        run_and_count("R8 len write");

        // every phase, slowest divisor, 31 dummies
        cmd_addr = 32'h0000_00C3; mode_byte = 8'hF0;
        wr_lo = 32'h0F1E_2D3C; wr_hi = 32'h4B5A_6978;
        set_cmd(8'h9F, 5'd31, 1, 2'd0, 1, 1, 3'd7, 1, 3'd2, 4'd15);
        run_and_count("R3 len all");

        // R10 R12: start pulse and field changes during a running command
        cmd_addr = 32'h00AB_CDEF;
        set_cmd(8'h0B, 5'd4, 1, 2'd2, 0, 0, 3'd0, 1, 3'd3, 4'd2);
        busy_cnt = 0;
        pulse_go();
        repeat (20) @(negedge clk);
        cmd_opcode = 8'hFF; cmd_addr = 32'hFFFF_FFFF; rd_bytes_m1 = 3'd7; clk_div_code = 4'd0;
        pulse_go();
        chk("R12 busy kept", 64'(cmd_busy), 64'd1);
        wait_done();
        chk("R12 R10 length", 64'(busy_cnt), 64'(m_len));

        // back-to-back command right after idle (R10)
        set_cmd(8'h06, 5'd0, 0, 2'd0, 0, 0, 3'd0, 0, 3'd0, 4'd0);
        busy_cnt = 0;
        pulse_go();
        chk("R10 cs low after go", 64'(spi_cs_n), 64'd0);
        wait_done();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(TCK * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule